// File: doc/BRIEF.md
# SPI Shift Engine (Master or Slave, Four Clock Modes)

This block moves one byte at a time over a four-wire serial link. It acts either as the clock-driving master or as a slave that follows an external clock, and it covers all four combinations of idle clock level (CPOL) and data phase (CPHA). A small register port on the system side gives access to one data location, one configuration location and one status location.

In master mode, writing the data location starts a transfer. The block lowers its select output and produces eight SCLK cycles from a parameterised divider of the system clock. In slave mode, the byte written ahead of time is shifted out while an external master clocks it. The slave's SCLK, MOSI and select inputs first pass through a synchroniser into the system clock domain, and SCLK edges are detected there.

When a transfer ends, a completion flag is set and the received byte is held for reading. A data write that lands while a byte is moving is refused and recorded in a sticky collision flag.

Top module: `spi_engine`

## Requirements
- R1: After reset, the data, configuration and status locations all read 0, `sclk_out` is 0, `sel_out_n` is 1 and `miso_oe` is 0. A configuration value of 0 means slave mode, CPOL 0, CPHA 0 and MSB first.
- R2: The register map is as follows. Address 0 is data: a write loads the transmit byte and a read returns the last received byte. Address 1 is configuration: bit0 selects master, bit1 is CPOL, bit2 is CPHA and bit3 selects LSB first. Address 2 is status: bit0 is done and bit1 is collision. In master mode with no transfer running, `sclk_out` rests at the CPOL level.
- R3: In master mode, an accepted data write drives `sel_out_n` low and produces exactly 16 SCLK edges, with consecutive edges `HALF_DIV` system clocks apart. After the sixteenth edge, `sel_out_n` returns high.
- R4: With CPHA=1, the outgoing bit changes on the first edge of each SCLK cycle and the incoming bit is sampled on the second edge. This holds in both roles.
- R5: With CPHA=0, the first outgoing bit is valid before the first edge. Each bit is sampled on the first edge of its cycle and the next bit is presented on the second edge. A master presents its first bit when the data write is accepted. A slave presents its first bit after select falls.
- R6: With configuration bit3 set, bits go out LSB first; otherwise they go out MSB first. The received byte is assembled in the same order.
- R7: The done bit is set once the eighth bit is complete. In master mode that is the sixteenth SCLK edge; in slave mode it is the eighth sampling edge. The done bit is cleared by writing 1 to status bit0 or by the next accepted data write. The received byte stays readable after done is cleared.
- R8: A data write made while a transfer is running sets the collision bit. It does not change the byte being shifted. The collision bit stays set until 1 is written to status bit1.
- R9: In slave mode with CPHA=1, a data write made outside a transfer is accepted whether the select input is high or low.
- R10: In slave mode with CPHA=0, a data write made while the select input is low is a collision, and the byte shifted out is the one loaded earlier.
- R11: `miso_oe` is 1 only in slave mode while the synchronised select is low. Raising the select ends any slave transfer in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Register read data for `bus_addr` |
| sclk_out | output | 1 | Serial clock driven in master mode |
| sclk_in | input | 1 | Serial clock received in slave mode |
| mosi_out | output | 1 | Master data out |
| mosi_in | input | 1 | Slave data in |
| miso_out | output | 1 | Slave data out |
| miso_oe | output | 1 | Output enable for `miso_out`; low means high impedance |
| miso_in | input | 1 | Master data in |
| sel_in_n | input | 1 | Slave select input, active low |
| sel_out_n | output | 1 | Slave select driven in master mode, active low |

## Verification
The hardest case to reach is a data write that lands in the middle of a byte. It has to occur after some SCLK edges have passed and before the last one, and both the flag and the undisturbed bit stream must then be observed. In master mode, the bench reacts to the block's own clock edges and issues the second write on the sixth edge while it keeps reconstructing the MOSI byte. In slave CPHA=0 mode, the bench lowers select, waits past the synchroniser, writes and then clocks the whole byte, expecting the byte loaded before the write.

// File: rtl/spi_pkg.sv
package spi_pkg;
  localparam int SPI_DW = 8;
  localparam int BIT_CW = $clog2(SPI_DW + 1);

  typedef logic [SPI_DW-1:0] spi_word_t;

  localparam logic [1:0] ADDR_DATA = 2'd0;
  localparam logic [1:0] ADDR_CTRL = 2'd1;
  localparam logic [1:0] ADDR_STAT = 2'd2;

  typedef struct packed {
    logic lsb_first;
    logic cpha;
    logic cpol;
    logic master;
  } spi_cfg_t;

  // bit presented on the line next
  function automatic logic out_bit(input spi_word_t d, input logic lsb);
    return lsb ? d[0] : d[SPI_DW-1];
  endfunction

  // shift out one bit and take the received bit in at the far end
  function automatic spi_word_t shift_in(input spi_word_t d, input logic b, input logic lsb);
    return lsb ? {b, d[SPI_DW-1:1]} : {d[SPI_DW-2:0], b};
  endfunction
endpackage

// File: rtl/spi_sync.sv
module spi_sync #(
  parameter int W = 3,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/spi_clkgen.sv
module spi_clkgen
  import spi_pkg::*;
#(
  parameter int HALF_DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic cpol,
  output logic sclk,
  output logic tick,
  output logic lead,
  output logic last
);
  localparam int DIV_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam int ECW   = $clog2(2 * SPI_DW + 1);
  localparam logic [DIV_W-1:0] DIV_TOP  = DIV_W'(HALF_DIV - 1);
  localparam logic [ECW-1:0]   EDGE_TOP = ECW'(2 * SPI_DW - 1);

  logic             run;
  logic [DIV_W-1:0] div_cnt;
  logic [ECW-1:0]   edge_cnt;

  assign tick = run && (div_cnt == DIV_TOP);
  assign lead = tick && !edge_cnt[0];
  assign last = tick && (edge_cnt == EDGE_TOP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run      <= 1'b0;
      div_cnt  <= '0;
      edge_cnt <= '0;
      sclk     <= 1'b0;
    end else if (start) begin
      run      <= 1'b1;
      div_cnt  <= '0;
      edge_cnt <= '0;
      sclk     <= cpol;
    end else if (run) begin
      if (tick) begin
        div_cnt  <= '0;
        sclk     <= ~sclk;
        edge_cnt <= edge_cnt + 1'b1;
        if (edge_cnt == EDGE_TOP) run <= 1'b0;
      end else begin
        div_cnt <= div_cnt + 1'b1;
      end
    end else begin
      sclk <= cpol;
    end
  end

  AST_EDGE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    edge_cnt <= ECW'(2 * SPI_DW)) else $error("edge count overflow"); // R3
  AST_HALF_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !tick && !start) |=> $stable(sclk)) else $error("sclk moved mid half-period"); // R3
endmodule

// File: rtl/spi_engine.sv
module spi_engine
  import spi_pkg::*;
#(
  parameter int HALF_DIV    = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [1:0]        bus_addr,
  input  logic [SPI_DW-1:0] bus_wdata,
  output logic [SPI_DW-1:0] bus_rdata,
  output logic              sclk_out,
  input  logic              sclk_in,
  output logic              mosi_out,
  input  logic              mosi_in,
  output logic              miso_out,
  output logic              miso_oe,
  input  logic              miso_in,
  input  logic              sel_in_n,
  output logic              sel_out_n
);
  spi_cfg_t          cfg;
  logic              busy, done_flag, coll_flag, tx_bit;
  spi_word_t         shreg, rx_buf, shreg_next;
  logic [BIT_CW-1:0] bit_cnt;

  // register strobes
  logic wr_data, wr_ctrl, wr_stat;
  assign wr_data = bus_wr && (bus_addr == ADDR_DATA);
  assign wr_ctrl = bus_wr && (bus_addr == ADDR_CTRL);
  assign wr_stat = bus_wr && (bus_addr == ADDR_STAT);

  // slave pin synchroniser
  logic [2:0] syn_q;
  logic       s_ss_n, s_sclk, s_mosi, s_sclk_d, s_ss_d;
  spi_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({sel_in_n, sclk_in, mosi_in}), .q(syn_q)
  );
  assign s_ss_n = syn_q[2];
  assign s_sclk = syn_q[1];
  assign s_mosi = syn_q[0];

  // named internal events
  logic s_rise, s_fall, s_lead, s_trail, s_sel_fall, s_active;
  logic collide, accept, start_m;
  logic m_sclk, m_tick, m_lead, m_trail, m_last;
  logic slv_shift, slv_sample, slv_start0, shift_ev, sample_ev, last_sample, rx_in;

  assign s_rise     = s_sclk && !s_sclk_d;
  assign s_fall     = !s_sclk && s_sclk_d;
  assign s_lead     = cfg.cpol ? s_fall : s_rise;
  assign s_trail    = cfg.cpol ? s_rise : s_fall;
  assign s_sel_fall = s_ss_d && !s_ss_n;
  assign s_active   = !cfg.master && !s_ss_n;

  assign collide = wr_data && (busy || (!cfg.master && !cfg.cpha && !s_ss_n));
  assign accept  = wr_data && !collide;
  assign start_m = accept && cfg.master;

  spi_clkgen #(.HALF_DIV(HALF_DIV)) u_clkgen (
    .clk(clk), .rst_n(rst_n), .start(start_m), .cpol(cfg.cpol),
    .sclk(m_sclk), .tick(m_tick), .lead(m_lead), .last(m_last)
  );
  assign m_trail = m_tick && !m_lead;

  assign slv_shift  = s_active && (cfg.cpha ? s_lead : (s_trail && busy));
  assign slv_sample = s_active && busy && (cfg.cpha ? s_trail : s_lead);
  assign slv_start0 = !cfg.master && !cfg.cpha && s_sel_fall && !busy;

  assign shift_ev    = cfg.master ? (cfg.cpha ? m_lead : m_trail) : slv_shift;
  assign sample_ev   = cfg.master ? (cfg.cpha ? m_trail : m_lead) : slv_sample;
  assign last_sample = sample_ev && (bit_cnt == BIT_CW'(SPI_DW - 1));
  assign rx_in       = cfg.master ? miso_in : s_mosi;
  assign shreg_next  = shift_in(shreg, rx_in, cfg.lsb_first);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_sclk_d <= 1'b0;
      s_ss_d   <= 1'b1;
    end else begin
      s_sclk_d <= s_sclk;
      s_ss_d   <= s_ss_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg       <= '0;
      busy      <= 1'b0;
      done_flag <= 1'b0;
      coll_flag <= 1'b0;
      tx_bit    <= 1'b0;
      shreg     <= '0;
      rx_buf    <= '0;
      bit_cnt   <= '0;
    end else begin
      if (wr_ctrl) cfg <= spi_cfg_t'(bus_wdata[3:0]);

      // data path
      if (accept) begin
        shreg <= bus_wdata;
        if (cfg.master) begin
          busy    <= 1'b1;
          bit_cnt <= '0;
          if (!cfg.cpha) tx_bit <= out_bit(bus_wdata, cfg.lsb_first);
        end
      end else if (sample_ev) begin
        shreg <= shreg_next;
        if (last_sample) begin
          rx_buf  <= shreg_next;
          bit_cnt <= '0;
        end else begin
          bit_cnt <= bit_cnt + 1'b1;
        end
      end
      if (shift_ev) tx_bit <= out_bit(shreg, cfg.lsb_first);

      // slave framing
      if (slv_start0) begin
        busy    <= 1'b1;
        bit_cnt <= '0;
        tx_bit  <= out_bit(shreg, cfg.lsb_first);
      end
      if (slv_shift && cfg.cpha && !busy) begin
        busy    <= 1'b1;
        bit_cnt <= '0;
      end
      if (!cfg.master && last_sample) busy <= 1'b0;
      if (!cfg.master && s_ss_n && busy) begin
        busy    <= 1'b0;
        bit_cnt <= '0;
      end

      // master framing
      if (cfg.master && m_last) busy <= 1'b0;

      // status: set wins over clear
      if ((wr_stat && bus_wdata[0]) || accept) done_flag <= 1'b0;
      if ((cfg.master && m_last) || (!cfg.master && last_sample)) done_flag <= 1'b1;
      if (wr_stat && bus_wdata[1]) coll_flag <= 1'b0;
      if (collide) coll_flag <= 1'b1;
    end
  end

  // pins
  assign sclk_out  = cfg.master ? m_sclk : cfg.cpol;
  assign mosi_out  = cfg.master && tx_bit;
  assign miso_out  = tx_bit;
  assign miso_oe   = s_active;
  assign sel_out_n = !(cfg.master && busy);

  always_comb begin
    case (bus_addr)
      ADDR_DATA: bus_rdata = rx_buf;
      ADDR_CTRL: bus_rdata = {{(SPI_DW-4){1'b0}}, cfg};
      ADDR_STAT: bus_rdata = {{(SPI_DW-2){1'b0}}, coll_flag, done_flag};
      default:   bus_rdata = '0;
    endcase
  end

  AST_IDLE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg.master && !busy && $stable(cfg.cpol)) |-> (sclk_out == cfg.cpol)) else $error("idle level"); // R2
  AST_TICK_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg.master && m_tick) |-> busy) else $error("clock outside transfer"); // R3
  AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg.master && m_last) |=> done_flag) else $error("done missing"); // R7
  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    bit_cnt < BIT_CW'(SPI_DW)) else $error("bit count overflow"); // R7
  AST_COLL_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    collide |=> coll_flag) else $error("collision not flagged"); // R8
  AST_COLL_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (collide && !sample_ev) |=> $stable(shreg)) else $error("collision touched shifter"); // R8
  AST_SLV_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg.master && s_ss_n && busy) |=> !busy) else $error("slave kept busy"); // R11
endmodule

// File: tb/tb_spi_engine.sv
module tb_spi_engine;
  localparam int HALF = 4;
  localparam int SH   = 8;

  logic       clk = 1'b0, rst_n = 1'b0;
  logic       bus_wr = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic [7:0] bus_wdata = 8'd0, bus_rdata;
  logic       sclk_out, mosi_out, miso_out, miso_oe, sel_out_n;
  logic       sclk_in = 1'b0, mosi_in = 1'b0, miso_in = 1'b0, sel_in_n = 1'b1;

  int errs = 0, checks = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  spi_engine #(.HALF_DIV(HALF), .SYNC_STAGES(2)) dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .sclk_out(sclk_out), .sclk_in(sclk_in), .mosi_out(mosi_out),
    .mosi_in(mosi_in), .miso_out(miso_out), .miso_oe(miso_oe), .miso_in(miso_in),
    .sel_in_n(sel_in_n), .sel_out_n(sel_out_n)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  function automatic int pos(input int k, input bit lsb);
    return lsb ? k : 7 - k;
  endfunction

  task automatic t_reset;
    logic [7:0] v;
    bus_read(2'd0, v); chk("R1 data after reset", v, 0);
    bus_read(2'd1, v); chk("R1 config after reset", v, 0);
    bus_read(2'd2, v); chk("R1 status after reset", v, 0);
    chk("R1 sclk_out", sclk_out, 0);
    chk("R1 sel_out_n", sel_out_n, 1);
    chk("R1 miso_oe", miso_oe, 0);
  endtask

  // bench plays the slave against the block's master
  task automatic m_xfer(input bit cpol, input bit cpha, input bit lsb,
                        input logic [7:0] tx, input logic [7:0] stx, input bit do_coll);
    logic [7:0] got, v;
    logic prev;
    int edges, t, t1, t2, k;
    string ph;
    ph = cpha ? "R4" : "R5";
    got = 8'h00; edges = 0; t = 0; t1 = 0; t2 = 0;
    bus_write(2'd1, {4'b0, lsb, cpha, cpol, 1'b1});
    repeat (2) @(negedge clk);
    chk("R2 idle sclk level", sclk_out, cpol);
    chk("R11 miso_oe low in master", miso_oe, 0);
    if (!cpha) miso_in = stx[pos(0, lsb)];
    bus_write(2'd0, tx);
    chk("R3 select low", sel_out_n, 0);
    prev = cpol;
    while (edges < 16 && t < 2000) begin
      bus_wr = 1'b0;
      if (sclk_out != prev) begin
        edges++; prev = sclk_out; k = (edges - 1) / 2;
        if (edges == 1) t1 = t;
        if (edges == 2) t2 = t;
        if (cpha) begin
          if (edges % 2 == 1) miso_in = stx[pos(k, lsb)];
          else got[pos(k, lsb)] = mosi_out;
        end else begin
          if (edges % 2 == 1) got[pos(k, lsb)] = mosi_out;
          else if (k < 7) miso_in = stx[pos(k + 1, lsb)];
        end
        if (do_coll && edges == 6) begin
          bus_addr = 2'd0; bus_wdata = ~tx; bus_wr = 1'b1;
        end
      end
      @(negedge clk); t++;
    end
    bus_wr = 1'b0;
    chk("R3 edge count", edges, 16);
    chk("R3 half period", t2 - t1, HALF);
    chk({ph, " R6 mosi byte (R8 when colliding)"}, got, tx);
    repeat (2) @(negedge clk);
    chk("R3 select released", sel_out_n, 1);
    chk("R2 sclk back at idle", sclk_out, cpol);
    bus_read(2'd2, v);
    chk("R7 done set", v[0], 1);
    chk("R8 collision flag", v[1], do_coll);
    bus_read(2'd0, v);
    chk({ph, " R6 master received byte"}, v, stx);
    if (do_coll) begin
      bus_write(2'd2, 8'h02);
      bus_read(2'd2, v);
      chk("R8 collision cleared by W1C", v[1], 0);
    end
  endtask

  // bench plays the master against the block's slave
  task automatic s_xfer(input bit cpol, input bit cpha, input bit lsb,
                        input logic [7:0] pre, input logic [7:0] mtx,
                        input bit wr_sel_low, input bit do_coll);
    logic [7:0] got, v;
    string ph;
    ph = cpha ? "R4" : "R5";
    got = 8'h00;
    sclk_in = cpol; sel_in_n = 1'b1;
    bus_write(2'd1, {4'b0, lsb, cpha, cpol, 1'b0});
    repeat (4) @(negedge clk);
    chk("R11 miso_oe low with select high", miso_oe, 0);
    if (wr_sel_low) begin
      sel_in_n = 1'b0;
      repeat (4) @(negedge clk);
    end
    bus_write(2'd0, pre);
    bus_read(2'd2, v);
    chk("R9 preload accepted without collision", v[1], 0);
    chk("R7 done cleared by data write", v[0], 0);
    sel_in_n = 1'b0;
    if (!cpha) mosi_in = mtx[pos(0, lsb)];
    repeat (SH) @(negedge clk);
    chk("R11 miso_oe high with select low", miso_oe, 1);
    if (do_coll) begin
      bus_write(2'd0, ~pre);
      bus_read(2'd2, v);
      chk("R10 write with select low collides", v[1], 1);
      bus_write(2'd2, 8'h02);
    end
    for (int k = 0; k < 8; k++) begin
      if (cpha) begin
        sclk_in = ~sclk_in; mosi_in = mtx[pos(k, lsb)];
        repeat (SH) @(negedge clk);
        got[pos(k, lsb)] = miso_out;
        sclk_in = ~sclk_in;
        repeat (SH) @(negedge clk);
      end else begin
        got[pos(k, lsb)] = miso_out;
        sclk_in = ~sclk_in;
        repeat (SH) @(negedge clk);
        sclk_in = ~sclk_in;
        if (k < 7) mosi_in = mtx[pos(k + 1, lsb)];
        repeat (SH) @(negedge clk);
      end
    end
    chk({ph, " R6 R10 slave miso byte"}, got, pre);
    bus_read(2'd2, v);
    chk("R7 slave done set", v[0], 1);
    bus_read(2'd0, v);
    chk({ph, " R6 slave received byte"}, v, mtx);
    sel_in_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R11 miso_oe released", miso_oe, 0);
    bus_write(2'd2, 8'h01);
    bus_read(2'd2, v);
    chk("R7 done cleared by W1C", v[0], 0);
    bus_read(2'd0, v);
    chk("R7 received byte kept", v, mtx);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    m_xfer(1'b0, 1'b1, 1'b0, 8'hC5, 8'h3A, 1'b0);
    m_xfer(1'b1, 1'b1, 1'b1, 8'h96, 8'h71, 1'b1);
    m_xfer(1'b0, 1'b0, 1'b0, 8'h1E, 8'hB4, 1'b0);
    m_xfer(1'b1, 1'b0, 1'b1, 8'h6D, 8'h0F, 1'b1);
    s_xfer(1'b0, 1'b1, 1'b0, 8'hA7, 8'h52, 1'b0, 1'b0);
    s_xfer(1'b1, 1'b1, 1'b1, 8'h39, 8'hE1, 1'b1, 1'b0);
    s_xfer(1'b0, 1'b0, 1'b0, 8'h5C, 8'h8B, 1'b0, 1'b1);
    s_xfer(1'b1, 1'b0, 1'b1, 8'hD2, 8'h27, 1'b0, 1'b0);
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; errs++;
      $display("FAIL watchdog R3 actual=hung expected=complete");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule